// File: doc/BRIEF.md
# Two-Group Keypad Select and Read Port

This block sits between a processor's I/O register space and an eight-button keypad wired as two four-button groups. One group holds the four direction keys and the other holds the four action keys. Software writes a two-bit select field into the port. Reading the port then returns the state of the chosen group as an active-low nibble, so a pressed key reads as 0. The live button inputs are active high. The direction keys sit in bits 3:0 of that vector and the action keys in bits 7:4.

When both groups are selected, the returned nibble merges the two groups so that a key pressed in either group shows as pressed. When neither group is selected, the port returns an identification nibble instead. Its value depends on a multiplayer-mode input.

The block also produces a one-cycle keypad interrupt request. The request fires when the selected nibble changes from "no key pressed" to "some key pressed". The block does not debounce the keys, and it has no interrupt controller of its own.

Top module: `kp_matrix_port`

## Requirements
- R1: After synchronous reset, the stored select field is 2'b11, so with multiplayer mode off the port reads 8'hFF and the interrupt output is 0.
- R2: A write (`wr_en` high at a clock edge) stores only `wr_data[5:4]` as the select field. Bits 7:6 and 3:0 of the written byte have no effect on the value read back. Read bits 5:4 always show the stored field.
- R3: Read bits 7:6 are always 1.
- R4: Select field 2'b01 picks the direction group `buttons[3:0]`. Select field 2'b10 picks the action group `buttons[7:4]`.
- R5: Select field 2'b00 picks the bitwise OR of `buttons[3:0]` and `buttons[7:4]`.
- R6: Select field 2'b11 picks 4'hF when `multi_mode` is 1 and 4'h0 when it is 0.
- R7: Read bits 3:0 are the bitwise inverse of the picked nibble, so a pressed key reads 0. The full read value is {2'b11, select, ~picked}.
- R8: When the picked nibble goes from zero to nonzero, `irq` is high for exactly one cycle. That cycle starts at the first clock edge after the change.
- R9: `irq` is not raised again while the picked nibble stays nonzero. Keys in a group that is not selected do not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the select register |
| wr_data | input | 8 | Written byte; only bits 5:4 are kept |
| buttons | input | 8 | Live key state, 1 = pressed; [3:0] direction, [7:4] action |
| multi_mode | input | 1 | Chooses the ID nibble returned when neither group is selected |
| rd_data | output | 8 | Port read value (combinational) |
| irq | output | 1 | One-cycle keypad interrupt request |

## Verification
The checker watches several behaviours on every cycle:
- the two top read bits stay high;
- the select bits track writes and hold between them;
- the reset value of the select field;
- the interrupt lasts a single cycle, follows a zero-to-nonzero change of the picked nibble, and always appears after such a change.

The bench scenarios cover the parts that depend on each specific select code:
- the mapping of each select code to a button group;
- the OR merge of both groups;
- the two ID values;
- keys in an unselected group staying silent.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int GRP_W  = 4;
    localparam int KEY_W  = 2 * GRP_W;
    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        SEL_BOTH = 2'b00,
        SEL_DIR  = 2'b01,
        SEL_ACT  = 2'b10,
        SEL_NONE = 2'b11
    } sel_e;

    typedef struct packed {
        logic [GRP_W-1:0] act;
        logic [GRP_W-1:0] dir;
    } keys_t;

    function automatic logic [GRP_W-1:0] pick_nibble(sel_e sel, keys_t k, logic multi);
        logic [GRP_W-1:0] n;
        unique case (sel)
            SEL_BOTH: n = k.dir | k.act;
            SEL_DIR:  n = k.dir;
            SEL_ACT:  n = k.act;
            default:  n = multi ? {GRP_W{1'b1}} : {GRP_W{1'b0}};
        endcase
        return n;
    endfunction
endpackage

// File: rtl/kp_sel_reg.sv
module kp_sel_reg
    import kp_pkg::*;
#(
    parameter int SEL_LSB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output sel_e              sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SEL_NONE;
        end else if (wr_en) begin
            sel <= sel_e'(wr_data[SEL_LSB +: 2]);
        end
    end
endmodule

// File: rtl/kp_group_mux.sv
module kp_group_mux
    import kp_pkg::*;
(
    input  sel_e             sel,
    input  keys_t            keys,
    input  logic             multi_mode,
    output logic [GRP_W-1:0] nibble
);
    always_comb begin
        nibble = pick_nibble(sel, keys, multi_mode);
    end
endmodule

// File: rtl/kp_irq_gen.sv
module kp_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic irq
);
    logic cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            cond_q <= cond;
            irq    <= cond & ~cond_q;
        end
    end
endmodule

// File: rtl/kp_matrix_port.sv
module kp_matrix_port
    import kp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [KEY_W-1:0]  buttons,
    input  logic              multi_mode,
    output logic [PORT_W-1:0] rd_data,
    output logic              irq
);
    sel_e             sel;
    logic [GRP_W-1:0] nibble;
    keys_t            keys;

    assign keys = keys_t'(buttons);

    kp_sel_reg #(.SEL_LSB(4)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sel     (sel)
    );

    kp_group_mux u_mux (
        .sel        (sel),
        .keys       (keys),
        .multi_mode (multi_mode),
        .nibble     (nibble)
    );

    kp_irq_gen u_irq (
        .clk  (clk),
        .rst  (rst),
        .cond (|nibble),
        .irq  (irq)
    );

    assign rd_data = {2'b11, sel, ~nibble};
endmodule

// File: rtl/kp_matrix_port_chk.sv
module kp_matrix_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq
);
    AST_RESET_SEL: assert property (@(posedge clk) rst |=> rd_data[5:4] == 2'b11); // R1
    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[5:4] == $past(wr_data[5:4])); // R2
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data[5:4])); // R2
    AST_TOP_ONES: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:6] == 2'b11); // R3
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R8
    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (rd_data[3:0] != 4'hF && $past(rd_data[3:0]) == 4'hF) |=> irq); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(rd_data[3:0]) != 4'hF); // R9
endmodule

bind kp_matrix_port kp_matrix_port_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/kp_matrix_port_tb.sv
module kp_matrix_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] buttons = 8'h00;
    logic       multi_mode = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    kp_matrix_port u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .buttons(buttons), .multi_mode(multi_mode),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 read", rd_data, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_groups();
        buttons = 8'h5A;
        wr(8'h10);
        check("R4 dir", rd_data, 8'hD5);
        wr(8'h20);
        check("R4 act", rd_data, 8'hEA);
        buttons = 8'h21;
        wr(8'h00);
        check("R5 or", rd_data, 8'hCC);
        buttons = 8'h80;
        #1 check("R7 live act-only via or", rd_data, 8'hC7);
    endtask

    task automatic t_ignore();
        buttons = 8'h5A;
        wr(8'hDA);
        check("R2 bits kept 5:4 only", rd_data, 8'hD5);
        wr(8'h2F);
        check("R2 low bits ignored", rd_data, 8'hEA);
        wr(8'h0C);
        check("R3 top ones", rd_data, 8'hC0);
    endtask

    task automatic t_id();
        buttons = 8'hFF;
        multi_mode = 1'b0;
        wr(8'h30);
        check("R6 id off", rd_data, 8'hFF);
        multi_mode = 1'b1;
        #1 check("R6 id on", rd_data, 8'hF0);
        multi_mode = 1'b0;
        buttons = 8'h00;
    endtask

    task automatic t_irq();
        buttons = 8'h00;
        wr(8'h10);
        repeat (2) @(negedge clk);
        check("R8 idle", {7'd0, irq}, 8'h00);
        buttons = 8'h01;
        #1 check("R8 not early", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R8 pulse", {7'd0, irq}, 8'h01);
        @(negedge clk);
        check("R9 no repeat", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R9 held", {7'd0, irq}, 8'h00);
        buttons = 8'h00;
        repeat (2) @(negedge clk);
        buttons = 8'h10;
        @(negedge clk);
        check("R9 unselected", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R9 unselected later", {7'd0, irq}, 8'h00);
        buttons = 8'h00;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_groups();
        t_ignore();
        t_id();
        t_irq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule